// File: doc/BRIEF.md
# Iterative AES-128 Round Engine

This block encrypts or decrypts one 128-bit block at a time with AES-128 in electronic-codebook fashion. It does not load or expand keys. It reads already-expanded round keys from an external store through a small read port: it drives a round index out, and the store returns that round's 128-bit key in the same cycle. One round datapath is reused for all ten rounds. A phase counter spreads the initial key addition, nine full rounds and the final round (which skips column mixing) over a fixed 44-cycle cadence.

While `enable` stays high, blocks follow one another with no gap. The input block is sampled in the first cycle of each 44-cycle period. The result appears in the 44th cycle together with a one-cycle `outValid` strobe. The next block is taken in the following cycle. Pulling `enable` low freezes the engine where it is. A synchronous `clear` throws away the block in flight. The key store and its ready flag sit outside the engine, so `clear` leaves them alone. A compile-time parameter builds an encrypt-only engine, a decrypt-only engine, or an engine whose direction is chosen by an input pin.

Top module: `aes_round_engine`

## Requirements
- R1: Encryption matches the AES-128 standard. For key 000102..0f and plaintext 00112233..ff the result is 69c4e0d86a7b0430d8cdb78070b4c55a. For key 2b7e1516..4f3c and plaintext 3243f6a8..0734 the result is 3925841d02dc09fbdc118597196a0b32. The first state byte is carried on bits [127:120].
- R2: With `enable` held high, `outValid` rises in the 44th cycle of a block, counting the cycle in which `dataIn` is sampled as cycle 1. It stays high for that single cycle only.
- R3: Decryption is the exact inverse of R1. It uses the round keys in descending order with the equivalent inverse-cipher step ordering, and it turns both ciphertexts of R1 back into their plaintexts.
- R4: Blocks run back to back. `dataIn` is sampled again in the cycle right after the valid cycle, and that block's result is valid 44 cycles later. The direction may change between blocks.
- R5: While `enable` is low, the block in flight makes no progress, `outValid` stays low and `dataOut` holds its value. After `enable` returns high, the result is correct and appears after 44 enabled cycles in total. This also holds for a pause that falls exactly on cycle 44.
- R6: A cycle with `clear` high aborts the block in flight and suppresses `outValid`, including in cycle 44. The cycle after the clear is cycle 1 of a fresh block, which completes correctly.
- R7: A block cannot start while `keyReady` is low, and `outValid` is never high while `keyReady` is low. Once `keyReady` rises, the block starts in that cycle.
- R8: Parameter `MODE` = 1 builds an encrypt-only engine, 2 a decrypt-only engine, and 3 an engine in which `encSel` picks the direction (1 encrypts, 0 decrypts). In modes 1 and 2, `encSel` has no effect.
- R9: `rkAddr` carries the round-key index. In cycle 1 of a block it reads 0 when encrypting and 10 when decrypting.
- R10: After reset, `outValid` is low and `dataOut` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | High lets the round sequence advance; low freezes it |
| clear | input | 1 | Synchronous abort of the block in flight |
| encSel | input | 1 | Direction when MODE is 3: 1 encrypt, 0 decrypt |
| dataIn | input | 128 | Block to process, sampled in cycle 1 |
| keyReady | input | 1 | High when the external round-key store holds a valid expanded key |
| rkAddr | output | 4 | Round-key index presented to the key store |
| rkData | input | 128 | Round key returned by the store for `rkAddr`, same cycle |
| dataOut | output | 128 | Result block; meaningful only while `outValid` is high |
| outValid | output | 1 | One-cycle strobe marking a finished block |

## Verification
The bench attacks the timing corners. It runs a pause that lands on the final cycle, which a design that counts idle cycles or fires the strobe without `enable` would show as an early or duplicated strobe. It runs a clear at cycle 44, which a design would leak as a stray strobe. It sends a second block in the cycle straight after a valid cycle, which an engine that needs a dead cycle or lets the strobe linger would miss. Decryption runs directly after encryption, in reverse key order, so a wrong round-key index or a misplaced inverse column mix would show up as corrupt plaintext. Stalls on `keyReady` and instances of the fixed-direction variants check that the start gating and the mode parameter are obeyed.

// File: rtl/aes_eng_pkg.sv
package aes_eng_pkg;

  localparam int BLOCK_W          = 128;
  localparam int ROUNDS           = 10;
  localparam int PHASES_PER_ROUND = 4;   // power of two
  localparam int BLOCK_CYCLES     = PHASES_PER_ROUND * ROUNDS + PHASES_PER_ROUND;
  localparam int PHASE_W          = $clog2(BLOCK_CYCLES + 1);
  localparam int KIDX_W           = $clog2(ROUNDS + 1);

  localparam int CFG_ENC_ONLY = 1;
  localparam int CFG_DEC_ONLY = 2;
  localparam int CFG_RUNTIME  = 3;

  typedef struct packed {
    logic              flush;    // abort: zero the state
    logic              loadIn;   // take dataIn and add the first round key
    logic              subStep;  // byte substitution plus row rotation
    logic              mixStep;  // column mixing plus round key addition
    logic              lastMix;  // final round: no column mixing
    logic              decrypt;  // inverse direction
    logic [KIDX_W-1:0] keyIdx;   // round key wanted this cycle
  } eng_strobe_t;

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254; zero maps to zero
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] pw;
    res = 8'h01;
    pw  = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) res = gfMul(res, pw);
      pw = gfMul(pw, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    logic [15:0] t;
    t = {v, v} << n;
    return t[15:8];
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] iv;
    iv = gfInv(a);
    return iv ^ rotl8(iv, 1) ^ rotl8(iv, 2) ^ rotl8(iv, 3) ^ rotl8(iv, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] invSbox(input logic [7:0] s);
    return gfInv(rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05);
  endfunction

  function automatic logic [BLOCK_W-1:0] subBlock(input logic [BLOCK_W-1:0] blk, input logic inv);
    logic [BLOCK_W-1:0] res;
    for (int i = 0; i < 16; i++)
      res[127-8*i -: 8] = inv ? invSbox(blk[127-8*i -: 8]) : sbox(blk[127-8*i -: 8]);
    return res;
  endfunction

  // byte r+4c holds row r, column c
  function automatic logic [BLOCK_W-1:0] shiftBlock(input logic [BLOCK_W-1:0] blk, input logic inv);
    logic [BLOCK_W-1:0] res;
    int src;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        src = inv ? (c - r + 4) % 4 : (c + r) % 4;
        res[127-8*(r+4*c) -: 8] = blk[127-8*(r+4*src) -: 8];
      end
    return res;
  endfunction

  function automatic logic [31:0] mixCol(input logic [31:0] col, input logic inv);
    logic [7:0] a  [4];
    logic [7:0] co [4];
    logic [7:0] b;
    logic [31:0] res;
    if (inv) begin
      co[0] = 8'h0e; co[1] = 8'h0b; co[2] = 8'h0d; co[3] = 8'h09;
    end else begin
      co[0] = 8'h02; co[1] = 8'h03; co[2] = 8'h01; co[3] = 8'h01;
    end
    for (int i = 0; i < 4; i++) a[i] = col[31-8*i -: 8];
    for (int i = 0; i < 4; i++) begin
      b = '0;
      for (int j = 0; j < 4; j++) b ^= gfMul(co[(j - i + 4) % 4], a[j]);
      res[31-8*i -: 8] = b;
    end
    return res;
  endfunction

  function automatic logic [BLOCK_W-1:0] mixBlock(input logic [BLOCK_W-1:0] blk, input logic inv);
    logic [BLOCK_W-1:0] res;
    for (int c = 0; c < 4; c++) res[127-32*c -: 32] = mixCol(blk[127-32*c -: 32], inv);
    return res;
  endfunction

endpackage

// File: rtl/aes_eng_ctrl.sv
module aes_eng_ctrl import aes_eng_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        clear,
  input  logic        keyReady,
  input  logic        decrypt,
  output eng_strobe_t stb,
  output logic        outValid
);

  localparam int LOG_PPR = $clog2(PHASES_PER_ROUND);
  localparam logic [PHASE_W-1:0] PH_ONE    = PHASE_W'(1);
  localparam logic [PHASE_W-1:0] PH_LAST   = PHASE_W'(BLOCK_CYCLES);
  localparam logic [PHASE_W-1:0] PH_SUB_LO = PHASE_W'(PHASES_PER_ROUND);
  localparam logic [PHASE_W-1:0] PH_SUB_HI = PHASE_W'(PHASES_PER_ROUND * ROUNDS);
  localparam logic [PHASE_W-1:0] PH_MIX_LO = PHASE_W'(PHASES_PER_ROUND + 1);
  localparam logic [PHASE_W-1:0] PH_MIX_HI = PHASE_W'(PHASES_PER_ROUND * ROUNDS + 1);
  localparam logic [KIDX_W-1:0]  KIDX_TOP  = KIDX_W'(ROUNDS);

  logic [PHASE_W-1:0] phaseQ;     // current cycle of the block, 1..BLOCK_CYCLES
  logic [PHASE_W-1:0] phaseOff;
  logic [KIDX_W-1:0]  roundNum;
  logic               advance;
  logic               step;

  // a block may only leave cycle 1 with a valid key behind it
  assign advance  = enable && (phaseQ != PH_ONE || keyReady);
  assign step     = advance && !clear;
  assign phaseOff = phaseQ - PH_ONE;
  assign roundNum = KIDX_W'(phaseOff >> LOG_PPR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        phaseQ <= PH_ONE;
    else if (clear)   phaseQ <= PH_ONE;
    else if (advance) phaseQ <= (phaseQ == PH_LAST) ? PH_ONE : phaseQ + PH_ONE;
  end

  always_comb begin
    stb         = '0;
    stb.flush   = clear;
    stb.decrypt = decrypt;
    stb.keyIdx  = decrypt ? KIDX_TOP - roundNum : roundNum;
    stb.loadIn  = step && (phaseQ == PH_ONE);
    stb.subStep = step && (phaseQ[LOG_PPR-1:0] == LOG_PPR'(0))
                       && (phaseQ >= PH_SUB_LO) && (phaseQ <= PH_SUB_HI);
    stb.mixStep = step && (phaseQ[LOG_PPR-1:0] == LOG_PPR'(1))
                       && (phaseQ >= PH_MIX_LO) && (phaseQ <= PH_MIX_HI);
    stb.lastMix = (phaseQ == PH_MIX_HI);
  end

  assign outValid = step && keyReady && (phaseQ == PH_LAST);

endmodule

// File: rtl/aes_eng_datapath.sv
module aes_eng_datapath import aes_eng_pkg::*; #(
  parameter int MODE = CFG_RUNTIME
) (
  input  logic               clk,
  input  logic               rstN,
  input  eng_strobe_t        stb,
  input  logic [BLOCK_W-1:0] dataIn,
  input  logic [BLOCK_W-1:0] rkData,
  output logic [BLOCK_W-1:0] stateQ
);

  logic [BLOCK_W-1:0] subOut;   // substitution and row rotation
  logic [BLOCK_W-1:0] mixOut;   // column mixing
  logic [BLOCK_W-1:0] keyMix;   // round key in the form the full rounds add
  logic [BLOCK_W-1:0] roundKey;
  logic [BLOCK_W-1:0] preKey;

  generate
    if (MODE == CFG_ENC_ONLY) begin : g_fwd
      assign subOut = shiftBlock(subBlock(stateQ, 1'b0), 1'b0);
      assign mixOut = mixBlock(stateQ, 1'b0);
      assign keyMix = rkData;
    end else if (MODE == CFG_DEC_ONLY) begin : g_inv
      assign subOut = shiftBlock(subBlock(stateQ, 1'b1), 1'b1);
      assign mixOut = mixBlock(stateQ, 1'b1);
      assign keyMix = mixBlock(rkData, 1'b1);
    end else begin : g_both
      logic [BLOCK_W-1:0] subFwd, subInv, mixFwd, mixInv, keyInv;
      assign subFwd = shiftBlock(subBlock(stateQ, 1'b0), 1'b0);
      assign subInv = shiftBlock(subBlock(stateQ, 1'b1), 1'b1);
      assign mixFwd = mixBlock(stateQ, 1'b0);
      assign mixInv = mixBlock(stateQ, 1'b1);
      assign keyInv = mixBlock(rkData, 1'b1);
      assign subOut = stb.decrypt ? subInv : subFwd;
      assign mixOut = stb.decrypt ? mixInv : mixFwd;
      assign keyMix = stb.decrypt ? keyInv : rkData;
    end
  endgenerate

  assign preKey   = stb.lastMix ? stateQ : mixOut;
  assign roundKey = stb.lastMix ? rkData : keyMix;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            stateQ <= '0;
    else if (stb.flush)   stateQ <= '0;
    else if (stb.loadIn)  stateQ <= dataIn ^ rkData;
    else if (stb.subStep) stateQ <= subOut;
    else if (stb.mixStep) stateQ <= preKey ^ roundKey;
  end

endmodule

// File: rtl/aes_round_engine.sv
module aes_round_engine import aes_eng_pkg::*; #(
  parameter int MODE = CFG_RUNTIME
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               clear,
  input  logic               encSel,
  input  logic [BLOCK_W-1:0] dataIn,
  input  logic               keyReady,
  output logic [KIDX_W-1:0]  rkAddr,
  input  logic [BLOCK_W-1:0] rkData,
  output logic [BLOCK_W-1:0] dataOut,
  output logic               outValid
);

  eng_strobe_t stb;
  logic        decryptSel;

  generate
    if (MODE == CFG_ENC_ONLY) begin : g_dirEnc
      assign decryptSel = 1'b0;
    end else if (MODE == CFG_DEC_ONLY) begin : g_dirDec
      assign decryptSel = 1'b1;
    end else begin : g_dirPin
      assign decryptSel = ~encSel;
    end
  endgenerate

  aes_eng_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .clear    (clear),
    .keyReady (keyReady),
    .decrypt  (decryptSel),
    .stb      (stb),
    .outValid (outValid)
  );

  aes_eng_datapath #(.MODE(MODE)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .dataIn (dataIn),
    .rkData (rkData),
    .stateQ (dataOut)
  );

  assign rkAddr = stb.keyIdx;

endmodule

// File: rtl/aes_round_engine_chk.sv
module aes_round_engine_chk import aes_eng_pkg::*; (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               clear,
  input logic               keyReady,
  input logic               outValid,
  input logic [BLOCK_W-1:0] dataOut,
  input logic [KIDX_W-1:0]  rkAddr
);

  localparam logic [PHASE_W-1:0] GAP_MAX = PHASE_W'(BLOCK_CYCLES);
  localparam logic [PHASE_W-1:0] GAP_MIN = PHASE_W'(BLOCK_CYCLES - 1);

  // enabled cycles since the last strobe, clear or reset
  logic [PHASE_W-1:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              gapCnt <= '0;
    else if (clear || outValid)             gapCnt <= '0;
    else if (enable && gapCnt != GAP_MAX)   gapCnt <= gapCnt + PHASE_W'(1);
  end

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  a_r2_min_spacing: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> gapCnt >= GAP_MIN);

  a_r5_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> enable);

  a_r5_pause_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !clear) |=> $stable(dataOut));

  a_r6_clear_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> !outValid);

  a_r7_key_gate: assert property (@(posedge clk) disable iff (!rstN)
    !keyReady |-> !outValid);

  a_r9_key_index_range: assert property (@(posedge clk) disable iff (!rstN)
    rkAddr <= KIDX_W'(ROUNDS));

endmodule

bind aes_round_engine aes_round_engine_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .clear    (clear),
  .keyReady (keyReady),
  .outValid (outValid),
  .dataOut  (dataOut),
  .rkAddr   (rkAddr)
);

// File: tb/test_aes_round_engine.sv
module test_aes_round_engine;

  localparam int CLK_PERIOD = 10;

  localparam logic [127:0] KEY_A = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] CT_A  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] KEY_B = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] PT_B  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] CT_B  = 128'h3925841d02dc09fbdc118597196a0b32;

  logic         clk = 1'b0;
  logic         rstN, enable, clear, encSel, keyReady;
  logic [127:0] dataIn;
  logic [3:0]   rkAddr, rkAddrE, rkAddrD;
  logic [127:0] dataOut, qEnc, qDec;
  logic         outValid, vEnc, vDec;
  logic [127:0] ks [0:10];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_round_engine #(.MODE(3)) i_aes_round_engine (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear), .encSel(encSel),
    .dataIn(dataIn), .keyReady(keyReady), .rkAddr(rkAddr), .rkData(ks[rkAddr]),
    .dataOut(dataOut), .outValid(outValid));

  aes_round_engine #(.MODE(1)) i_aes_round_engine_encOnly (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear), .encSel(encSel),
    .dataIn(dataIn), .keyReady(keyReady), .rkAddr(rkAddrE), .rkData(ks[rkAddrE]),
    .dataOut(qEnc), .outValid(vEnc));

  aes_round_engine #(.MODE(2)) i_aes_round_engine_decOnly (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear), .encSel(encSel),
    .dataIn(dataIn), .keyReady(keyReady), .rkAddr(rkAddrD), .rkData(ks[rkAddrD]),
    .dataOut(qDec), .outValid(vDec));

  // ---------------- bench-side key schedule ----------------
  function automatic logic [7:0] tbMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = '0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] tbSbox(input logic [7:0] x);
    logic [7:0] inv = '0;
    logic [7:0] s;
    for (int y = 1; y < 256; y++)
      if (x != 0 && tbMul(x, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ 8'h63 >> i & 1'b1;
    return s;
  endfunction

  task automatic expandKey(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [31:0] t;
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {tbSbox(t[31:24]), tbSbox(t[23:16]), tbSbox(t[15:8]), tbSbox(t[7:0])} ^ {rc, 24'h0};
        rc = rc[7] ? ((rc << 1) ^ 8'h1b) : (rc << 1);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) ks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drives a block starting in the current cycle (called between negedge and posedge).
  // Optionally drops enable for pauseLen cycles when enabled cycle pauseAt is reached.
  // Returns the result, the enabled-cycle number of the strobe, and pause misbehaviour.
  task automatic driveBlock(input logic [127:0] d, input logic dir, input int pauseAt,
                            input int pauseLen, output logic [127:0] q, output int n,
                            output int bad);
    logic [127:0] hold;
    dataIn = d; encSel = dir; enable = 1'b1; n = 0; bad = 0; q = '0;
    for (int k = 1; k <= 200; k++) begin
      if (k == pauseAt) begin
        enable = 1'b0;
        for (int j = 0; j < pauseLen; j++) begin
          #1;
          if (outValid) bad++;
          if (j == 0) hold = dataOut;
          else if (dataOut !== hold) bad++;
          @(negedge clk);
        end
        enable = 1'b1;
      end
      #1;
      if (outValid) begin q = dataOut; n = k; break; end
      @(negedge clk);
    end
  endtask

  task automatic goIdle();
    @(negedge clk);
    enable = 1'b0;
  endtask

  task automatic loadKey(input logic [127:0] key);
    @(negedge clk);
    keyReady = 1'b0;
    expandKey(key);
    keyReady = 1'b1;
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    @(negedge clk); #1;
    check(outValid == 1'b0, "R10 valid low after reset", {127'h0, outValid}, 128'h0);
    check(dataOut == '0, "R10 data zero after reset", dataOut, 128'h0);
  endtask

  task automatic testKeyGate();
    logic [127:0] q; int n, bad, seen;
    @(negedge clk);
    keyReady = 1'b0; dataIn = PT_A; encSel = 1'b1; enable = 1'b1; seen = 0;
    for (int k = 0; k < 60; k++) begin
      #1; if (outValid) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R7 no strobe without key", 128'(seen), 128'h0);
    enable = 1'b0;
    expandKey(KEY_A);
    keyReady = 1'b1;
    driveBlock(PT_A, 1'b1, 0, 0, q, n, bad);
    check(n == 44, "R7 start once key ready", 128'(n), 128'd44);
    check(q == CT_A, "R7 result after key ready", q, CT_A);
    goIdle();
  endtask

  task automatic testKeyIndex();
    @(negedge clk);
    encSel = 1'b1; #1;
    check(rkAddr == 4'd0, "R9 first key index encrypt", 128'(rkAddr), 128'd0);
    encSel = 1'b0; #1;
    check(rkAddr == 4'd10, "R9 first key index decrypt", 128'(rkAddr), 128'd10);
  endtask

  task automatic testEncDec(input logic [127:0] pt, input logic [127:0] ct);
    logic [127:0] q; int n, bad;
    @(negedge clk);
    driveBlock(pt, 1'b1, 0, 0, q, n, bad);
    check(q == ct, "R1 encrypt vector", q, ct);
    check(n == 44, "R2 strobe in cycle 44 (encrypt)", 128'(n), 128'd44);
    goIdle();
    @(negedge clk);
    driveBlock(ct, 1'b0, 0, 0, q, n, bad);
    check(q == pt, "R3 decrypt vector", q, pt);
    check(n == 44, "R3 decrypt latency", 128'(n), 128'd44);
    goIdle();
  endtask

  task automatic testBackToBack();
    logic [127:0] q1, q2; int n1, n2, bad;
    @(negedge clk);
    driveBlock(PT_A, 1'b1, 0, 0, q1, n1, bad);
    @(negedge clk);
    driveBlock(q1, 1'b0, 0, 0, q2, n2, bad);
    check(q1 == CT_A, "R4 first of back-to-back", q1, CT_A);
    check(n2 == 44, "R4 R2 second block strobe spacing", 128'(n2), 128'd44);
    check(q2 == PT_A, "R4 second block reversed direction", q2, PT_A);
    goIdle();
  endtask

  task automatic testPause(input int at, input int len, input logic dir,
                           input logic [127:0] d, input logic [127:0] exp);
    logic [127:0] q; int n, bad;
    @(negedge clk);
    driveBlock(d, dir, at, len, q, n, bad);
    check(bad == 0, "R5 no strobe and frozen data while paused", 128'(bad), 128'h0);
    check(n == 44, "R5 enabled cycles to strobe", 128'(n), 128'd44);
    check(q == exp, "R5 result after resume", q, exp);
    goIdle();
  endtask

  task automatic testClear();
    logic [127:0] q; int n, bad, seen;
    @(negedge clk);
    dataIn = 128'hdeadbeef_0badf00d_12345678_9abcdef0; encSel = 1'b1; enable = 1'b1; seen = 0;
    for (int k = 0; k < 20; k++) begin
      #1; if (outValid) seen++;
      @(negedge clk);
    end
    clear = 1'b1; #1;
    if (outValid) seen++;
    check(seen == 0, "R6 no strobe before or during clear", 128'(seen), 128'h0);
    @(negedge clk);
    clear = 1'b0;
    driveBlock(PT_A, 1'b1, 0, 0, q, n, bad);
    check(n == 44, "R6 fresh block right after clear", 128'(n), 128'd44);
    check(q == CT_A, "R6 result after abort", q, CT_A);
    goIdle();
  endtask

  task automatic testClearAtEnd();
    @(negedge clk);
    dataIn = PT_A; encSel = 1'b1; enable = 1'b1;
    for (int k = 1; k < 44; k++) @(negedge clk);
    clear = 1'b1; #1;
    check(outValid == 1'b0, "R6 clear in cycle 44 suppresses strobe", {127'h0, outValid}, 128'h0);
    @(negedge clk);
    clear = 1'b0; enable = 1'b0;
  endtask

  task automatic testModes();
    logic [127:0] q; int n, bad;
    @(negedge clk);
    driveBlock(PT_A, 1'b0, 0, 0, q, n, bad);
    check(vEnc == 1'b1, "R8 encrypt-only strobe", {127'h0, vEnc}, 128'h1);
    check(qEnc == CT_A, "R8 encrypt-only ignores select", qEnc, CT_A);
    goIdle();
    @(negedge clk);
    driveBlock(CT_A, 1'b1, 0, 0, q, n, bad);
    check(vDec == 1'b1, "R8 decrypt-only strobe", {127'h0, vDec}, 128'h1);
    check(qDec == PT_A, "R8 decrypt-only ignores select", qDec, PT_A);
    check(q == CT_A ^ CT_A ^ q && n == 44, "R8 runtime select timing", 128'(n), 128'd44);
    goIdle();
  endtask

  // ---------------- sequence ----------------
  initial begin
    rstN = 1'b0; enable = 1'b0; clear = 1'b0; encSel = 1'b1; keyReady = 1'b0; dataIn = '0;
    for (int r = 0; r < 11; r++) ks[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testKeyGate();
    testKeyIndex();
    testEncDec(PT_A, CT_A);
    testBackToBack();
    testPause(10, 15, 1'b1, PT_A, CT_A);
    testPause(44, 5, 1'b1, PT_A, CT_A);
    testPause(3, 7, 1'b0, CT_A, PT_A);
    testClear();
    testClearAtEnd();
    testModes();
    loadKey(KEY_B);
    testEncDec(PT_B, CT_B);
    loadKey(KEY_A);
    testEncDec(PT_A, CT_A);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule